// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a target on a two-wire serial bus. Behind it sits a byte memory held in flip-flops. The bus lines reach it as plain inputs. They are synchronised and edge-detected on the system clock. The block drives the data line only through an open-drain pull-down enable. A bus controller selects the block with a control byte. That byte carries a fixed four-bit device code and the three bits wired on the strap inputs, so up to eight of these targets can share one bus.

A write names one word address and then one data byte. The byte is committed to the memory only when a STOP closes the transfer. That STOP also starts a self-timed programming window. While the window runs, the target acknowledges nothing, so a controller can poll with control bytes until one is acknowledged. A read streams bytes from an internal address pointer. The pointer advances after each byte and wraps at the top of the memory. The read goes on until the controller leaves an acknowledge bit high.

Top module: `twe_eeprom_target`

## Requirements
- R1: A falling SDA while SCL is high (START) begins a new command from any state, including the middle of a byte. The partial byte is discarded and the next eight bits are decoded as a control byte.
- R2: A rising SDA while SCL is high (STOP) returns the target to idle with SDA released. Bits clocked after a STOP and before the next START get no acknowledge.
- R3: The target acknowledges a control byte only if bits 7..4 equal 1010 and bits 3..1 equal strap_i[2:0]. Bit 0 selects the direction: 0 is a write, 1 is a read. Bits are sent MSB first. After a control byte that does not match, no byte is acknowledged until the next START.
- R4: For every byte it accepts (a matching control byte, the word address, the first data byte), the target holds SDA low through the high period of the ninth clock.
- R5: A write is a control byte with bit 0 = 0, then a word-address byte, then a data byte, then a STOP. Only that STOP stores the data at the address and leaves the pointer at address + 1. A STOP that comes before a complete data byte stores nothing and starts no programming window. Bytes after the first data byte get no acknowledge and have no effect.
- R6: For PROG_CYCLES system clocks after a storing STOP, the target acknowledges nothing, not even a matching control byte. Afterwards it acknowledges again.
- R7: A control byte with bit 0 = 1 starts a read at the pointer. Each byte is driven MSB first while SCL is low. The pointer advances after each byte and wraps from MEM_DEPTH-1 to 0.
- R8: If the controller leaves the acknowledge bit after a read byte high, the target stops driving. SDA stays released until the next START or STOP.
- R9: The target changes its SDA drive only while SCL is low.
- R10: After reset, SDA is released, every memory byte reads 0, the pointer is 0 and no programming window is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| strap_i | input | 3 | Chip-select strap bits compared with control bits 3..1 |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
The bench builds the block with PROG_CYCLES = 300 and the default MEM_DEPTH = 256. The short programming window lets one run hit a control byte inside the window, which must not be acknowledged, and then poll past the window within a few thousand cycles. The full 256-byte depth lets a read cross the wrap from address 255 to 0. The strap inputs are tied to 101, so a control byte carrying 010 exercises the device-select mismatch path.

// File: rtl/twe_pkg.sv
`timescale 1ns/1ps
package twe_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_MACK,
        ST_SKIP
    } twe_state_e;
endpackage

// File: rtl/twe_line_sync.sv
`timescale 1ns/1ps
module twe_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] prv_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-1:0], raw_i[g]};
        end
        assign lvl_o[g] = chain_q[STAGES-1];
        assign prv_o[g] = chain_q[STAGES];
    end
endmodule

// File: rtl/twe_byte_store.sv
`timescale 1ns/1ps
module twe_byte_store #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
        end else if (we_i) begin
            cell_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cell_q[raddr_i];
endmodule

// File: rtl/twe_prog_timer.sv
`timescale 1ns/1ps
module twe_prog_timer #(
    parameter int CYCLES = 50000,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic busy_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (go_i)              cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R6: the window shrinks by one each clock until it ends
    p_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !go_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/twe_eeprom_target.sv
`timescale 1ns/1ps
module twe_eeprom_target #(
    parameter int MEM_DEPTH   = 256,
    parameter int PROG_CYCLES = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_pull_o
);
    import twe_pkg::*;

    localparam int AW = $clog2(MEM_DEPTH);
    localparam int CW = $clog2(BYTE_W + 1);

    typedef struct packed {
        twe_state_e        state;
        twe_state_e        nxt;
        logic [CW-1:0]     cnt;
        logic [BYTE_W-1:0] shift;
        logic [BYTE_W-1:0] tx;
        logic [AW-1:0]     ptr;
        logic [BYTE_W-1:0] wdata;
        logic              wr_pend;
        logic              mack;
        logic              pull;
    } regs_t;

    regs_t d, q;

    logic [1:0] lvl, prv;
    logic scl_s, sda_s, scl_p, sda_p;
    logic start_det, stop_det, scl_rise, scl_fall;
    logic mem_we, prog_go, prog_busy;
    logic [BYTE_W-1:0] rd_byte;

    twe_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}),
        .lvl_o(lvl), .prv_o(prv)
    );

    assign {scl_s, sda_s} = lvl;
    assign {scl_p, sda_p} = prv;
    assign start_det = scl_s && scl_p && sda_p && !sda_s;
    assign stop_det  = scl_s && scl_p && !sda_p && sda_s;
    assign scl_rise  = scl_s && !scl_p;
    assign scl_fall  = !scl_s && scl_p;

    twe_byte_store #(.DEPTH(MEM_DEPTH), .DW(BYTE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we_i(mem_we), .waddr_i(q.ptr),
        .wdata_i(q.wdata), .raddr_i(q.ptr), .rdata_o(rd_byte)
    );

    twe_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .go_i(prog_go), .busy_o(prog_busy)
    );

    always_comb begin
        d       = q;
        mem_we  = 1'b0;
        prog_go = 1'b0;
        if (start_det) begin
            d.state   = ST_CTRL;
            d.cnt     = '0;
            d.pull    = 1'b0;
            d.wr_pend = 1'b0;
        end else if (stop_det) begin
            if (q.wr_pend) begin
                mem_we  = 1'b1;
                prog_go = 1'b1;
                d.ptr   = q.ptr + 1'b1;
            end
            d.state   = ST_IDLE;
            d.pull    = 1'b0;
            d.wr_pend = 1'b0;
        end else begin
            case (q.state)
                ST_CTRL, ST_ADDR, ST_WDATA: begin
                    if (scl_rise && q.cnt < CW'(BYTE_W)) begin
                        d.shift = {q.shift[BYTE_W-2:0], sda_s};
                        d.cnt   = q.cnt + 1'b1;
                    end
                    if (scl_fall && q.cnt == CW'(BYTE_W)) begin
                        d.state = ST_ACK;
                        d.pull  = 1'b1;
                        if (q.state == ST_CTRL) begin
                            d.nxt = q.shift[0] ? ST_RDATA : ST_ADDR;
                            if (q.shift[7:1] != {DEV_CODE, strap_i} || prog_busy) begin
                                d.state = ST_SKIP;
                                d.pull  = 1'b0;
                            end
                        end else if (q.state == ST_ADDR) begin
                            d.ptr = q.shift[AW-1:0];
                            d.nxt = ST_WDATA;
                        end else begin
                            d.wdata   = q.shift;
                            d.wr_pend = 1'b1;
                            d.nxt     = ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.pull  = 1'b0;
                        d.cnt   = '0;
                        d.state = q.nxt;
                        if (q.nxt == ST_RDATA) begin
                            d.tx   = rd_byte;
                            d.ptr  = q.ptr + 1'b1;
                            d.pull = !rd_byte[BYTE_W-1];
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) d.cnt = q.cnt + 1'b1;
                    if (scl_fall) begin
                        if (q.cnt == CW'(BYTE_W)) begin
                            d.pull  = 1'b0;
                            d.state = ST_MACK;
                        end else begin
                            d.tx   = q.tx << 1;
                            d.pull = !q.tx[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) d.mack = !sda_s;
                    if (scl_fall) begin
                        if (q.mack) begin
                            d.state = ST_RDATA;
                            d.cnt   = '0;
                            d.tx    = rd_byte;
                            d.ptr   = q.ptr + 1'b1;
                            d.pull  = !rd_byte[BYTE_W-1];
                        end else begin
                            d.state = ST_SKIP;
                        end
                    end
                end
                default: d.pull = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.nxt   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.pull;

    // R1: a START always restarts control-byte decoding
    p_start_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (q.state == ST_CTRL && q.cnt == '0));
    // R2: a STOP leaves the target idle with the line released
    p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.state == ST_IDLE && !sda_pull_o));
    // R4: the bit counter never runs past one byte
    p_bitcount_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(BYTE_W));
    // R5: a storing STOP opens the programming window
    p_store_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && q.wr_pend) |=> prog_busy);
    // R6: nothing is driven during the programming window
    p_quiet_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> !sda_pull_o);
    // R9: drive changes follow a low SCL
    p_scl_low_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_p);
endmodule

// File: tb/twe_eeprom_target_bench.sv
`timescale 1ns/1ps
module twe_eeprom_target_bench;
    localparam int H    = 8;
    localparam int PROG = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_pull;
    logic       sda_line;

    int vectors = 0;
    int fails   = 0;
    int r9_bad  = 0;
    bit done    = 1'b0;

    string exp_tag[$];
    int    exp_val[$];
    int    act_val[$];

    localparam logic [7:0] CW_WR = 8'hAA;  // 1010 101 0
    localparam logic [7:0] CW_RD = 8'hAB;  // 1010 101 1

    assign sda_line = sda_m & ~sda_pull;

    always #10 clk = ~clk;

    twe_eeprom_target #(.MEM_DEPTH(256), .PROG_CYCLES(PROG), .SYNC_STAGES(2))
        u_twe_eeprom_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .strap_i(strap), .sda_pull_o(sda_pull)
    );

    // scoreboard monitor: compare expected against observed bus results
    always @(negedge clk) begin
        if (exp_val.size() > 0 && act_val.size() > 0) begin
            string t;
            int e, a;
            t = exp_tag.pop_front();
            e = exp_val.pop_front();
            a = act_val.pop_front();
            vectors++;
            if (e != a) begin
                fails++;
                $display("FAIL %s actual=%0h expected=%0h", t, a, e);
            end
        end
    end

    // R9 monitor: drive must not change while SCL is high
    logic pull_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_pull != pull_prev && scl_m) r9_bad++;
        pull_prev = sda_pull;
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b, output logic s);
        wait_n(H/2); sda_m = b;
        wait_n(H/2); scl_m = 1'b1;
        wait_n(H/2); s = sda_line;
        wait_n(H/2); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        wait_n(H/2); sda_m = 1'b1;
        wait_n(H/2); scl_m = 1'b1;
        wait_n(H);   sda_m = 1'b0;
        wait_n(H);   scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(H/2); sda_m = 1'b0;
        wait_n(H/2); scl_m = 1'b1;
        wait_n(H);   sda_m = 1'b1;
        wait_n(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        exp_tag.push_back(tag); exp_val.push_back(int'(exp_ack));
        act_val.push_back(int'(!s));
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic mack, input string tag);
        logic s;
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        exp_tag.push_back(tag); exp_val.push_back(int'(exp));
        act_val.push_back(int'(v));
        clk_bit(!mack, s);
    endtask

    task automatic write_byte(input logic [7:0] a, input logic [7:0] v, input string tag);
        bus_start();
        send_byte(CW_WR, 1'b1, {tag, " ctrl ack R4"});
        send_byte(a,     1'b1, {tag, " addr ack R4"});
        send_byte(v,     1'b1, {tag, " data ack R4"});
        bus_stop();
        wait_n(PROG + 100);
    endtask

    task automatic finish_run();
        wait_n(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic s;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);
        chk("R10 released after reset", int'(sda_pull), 0);

        // R10: pointer 0, memory cleared
        bus_start();
        send_byte(CW_RD, 1'b1, "R3 read ctrl ack");
        recv_byte(8'h00, 1'b0, "R10 reset byte at 0");
        wait_n(4);
        chk("R8 released after nack", int'(sda_pull), 0);
        bus_stop();

        // R3: wrong strap bits, then ignored until next START
        bus_start();
        send_byte(8'hA4, 1'b0, "R3 strap mismatch nack");
        send_byte(8'h10, 1'b0, "R3 later byte ignored");
        bus_stop();

        // R2: stray byte after STOP with no START
        wait_n(H); scl_m = 1'b0;
        send_byte(CW_WR, 1'b0, "R2 no ack without start");
        bus_stop();

        // R5/R6: write then poll during window
        bus_start();
        send_byte(CW_WR, 1'b1, "R4 ctrl ack");
        send_byte(8'h10, 1'b1, "R4 addr ack");
        send_byte(8'h5A, 1'b1, "R5 data ack");
        bus_stop();
        bus_start();
        send_byte(CW_WR, 1'b0, "R6 busy no ack");
        bus_stop();
        wait_n(PROG + 100);

        // R6 ack resumes; random read via repeated START
        bus_start();
        send_byte(CW_WR, 1'b1, "R6 ack after window");
        send_byte(8'h10, 1'b1, "R4 addr ack");
        bus_start();
        send_byte(CW_RD, 1'b1, "R3 read ctrl ack");
        recv_byte(8'h5A, 1'b1, "R7 stored byte");
        recv_byte(8'h00, 1'b0, "R7 next byte");
        bus_stop();

        // R7 wrap from 255 to 0
        write_byte(8'hFF, 8'hC3, "wr FF");
        write_byte(8'h00, 8'h3C, "wr 00");
        bus_start();
        send_byte(CW_WR, 1'b1, "R4 ctrl ack");
        send_byte(8'hFF, 1'b1, "R4 addr ack");
        bus_start();
        send_byte(CW_RD, 1'b1, "R3 read ctrl ack");
        recv_byte(8'hC3, 1'b1, "R7 byte at 255");
        recv_byte(8'h3C, 1'b1, "R7 wrap to 0");
        recv_byte(8'h00, 1'b0, "R7 byte at 1");
        bus_stop();

        // R5: STOP before data stores nothing, no busy window
        bus_start();
        send_byte(CW_WR, 1'b1, "R4 ctrl ack");
        send_byte(8'h20, 1'b1, "R4 addr ack");
        bus_stop();
        bus_start();
        send_byte(CW_RD, 1'b1, "R5 no window after addr-only");
        recv_byte(8'h00, 1'b0, "R5 nothing stored at 20");
        bus_stop();

        // R5: extra data byte refused
        bus_start();
        send_byte(CW_WR, 1'b1, "R4 ctrl ack");
        send_byte(8'h30, 1'b1, "R4 addr ack");
        send_byte(8'h11, 1'b1, "R5 first data ack");
        send_byte(8'h22, 1'b0, "R5 extra data nack");
        bus_stop();
        wait_n(PROG + 100);
        bus_start();
        send_byte(CW_WR, 1'b1, "R4 ctrl ack");
        send_byte(8'h30, 1'b1, "R4 addr ack");
        bus_start();
        send_byte(CW_RD, 1'b1, "R3 read ctrl ack");
        recv_byte(8'h11, 1'b1, "R5 first data kept");
        recv_byte(8'h00, 1'b0, "R5 extra data dropped");
        bus_stop();

        // R1: START in the middle of a byte
        bus_start();
        send_byte(CW_WR, 1'b1, "R4 ctrl ack");
        clk_bit(1'b0, s); clk_bit(1'b0, s); clk_bit(1'b0, s);
        bus_start();
        send_byte(CW_WR, 1'b1, "R1 ctrl ack after mid-byte start");
        send_byte(8'h10, 1'b1, "R1 addr ack");
        bus_start();
        send_byte(CW_RD, 1'b1, "R1 read ctrl ack");
        recv_byte(8'h5A, 1'b0, "R1 data after restart");
        bus_stop();

        wait_n(10);
        chk("R9 no drive change while SCL high", r9_bad, 0);
        while (exp_val.size() > 0) wait_n(1);
        done = 1'b1;
        finish_run();
    end
endmodule